// File: doc/BRIEF.md
# Accumulator Processor with Register-Transfer Sequencer

This block is a small single-accumulator processor. Its control unit runs each instruction through four phases: fetch, decode, execute and a closing reset phase. The reset phase hands control back to the program counter. All traffic to and from memory goes through a memory address register (MAR) and a memory data register (MDR). Immediate operands also pass through the MDR. As a result, the current instruction register (CIR) keeps the instruction word unchanged for the whole execute phase.

The processor drives one synchronous single-port memory that holds both instructions and data. It presents an address and a write strobe, and it receives the read word one clock after the address is presented. A byte-wide output port carries a one-cycle valid strobe for each output instruction. The block has no flags, interrupts, calls or pipelining.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register is cleared. In the cycle after such an edge, `out_valid` and `mem_we` are 0 and `mem_addr` is 0. After release, the first instruction is fetched from address 0 with the accumulator at 0.
- R2: Fetch copies the program counter into the MAR, reads the addressed word into the MDR, increments the program counter by exactly 1 and moves the MDR into the CIR. Instructions therefore run from consecutive addresses.
- R3: An instruction word is 12 bits: opcode in bits 11:8, address or immediate field in bits 7:0. Opcode 1 (jump) loads the field into the program counter.
- R4: Opcode 3 (load from memory) copies the low 8 bits of the word at the field address into the accumulator. Opcode 6 (add from memory) adds those 8 bits to the accumulator. Both go through the MAR and the MDR.
- R5: Opcode 2 (load immediate) places the field into the MDR and then into the accumulator. Opcode 5 (add immediate) places the field into the MDR and then adds it to the accumulator. Every addition wraps modulo 256.
- R6: Opcode 4 (store) writes the accumulator, zero-extended to 12 bits, to the field address in exactly one write cycle.
- R7: Opcode 7 drives `out_data` with the accumulator. Opcode 8 drives `out_data` with the low 8 bits of the word at the field address and leaves the accumulator unchanged.
- R8: Opcodes 0 and 9 to 15 are no-operations: no memory write, no output and no accumulator change.
- R9: `out_valid` is high for exactly one cycle per output instruction.
- R10: Cycles per instruction, counting the reset phase:
  - no-operation: 6
  - jump and output accumulator: 7
  - immediate load and immediate add: 8
  - store: 9
  - load, add and output from memory: 10
- R11: `mem_we` is raised only by a store instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | ADDR_W | Memory address, driven from the MAR |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 4+ADDR_W | Memory write word, driven from the MDR |
| mem_rdata | input | 4+ADDR_W | Memory read word, valid one cycle after the address |
| out_data | output | DATA_W | Output value |
| out_valid | output | 1 | One-cycle strobe marking `out_data` valid |

## Verification
The assertions check the register transfers on every cycle:
- the program counter steps by one during fetch;
- the CIR is loaded from the MDR and then held;
- a jump lands on the field value;
- an addition wraps modulo 256;
- a write goes to the CIR field with the accumulator as data;
- the reset phase returns to fetch;
- the output strobe never lasts two cycles.

Only the bench scenarios can show the end-to-end behaviour:
- each opcode's visible result, including the 8-bit wrap;
- that undefined opcodes leave no trace;
- the exact cycle spacing between outputs for each instruction class;
- that a reset in the middle of a program restarts it at address 0.

// File: rtl/acc_cpu_pkg.sv
// acc_cpu_pkg: shared opcode values, sequencer states and the control
// word passed from the sequencer to the datapath. The opcode field width
// is fixed here; address and data widths are parameters of the modules.
package acc_cpu_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OPC_JMP  = 4'd1;
    localparam logic [OP_W-1:0] OPC_LDI  = 4'd2;
    localparam logic [OP_W-1:0] OPC_LDM  = 4'd3;
    localparam logic [OP_W-1:0] OPC_STO  = 4'd4;
    localparam logic [OP_W-1:0] OPC_ADI  = 4'd5;
    localparam logic [OP_W-1:0] OPC_ADM  = 4'd6;
    localparam logic [OP_W-1:0] OPC_OUTA = 4'd7;
    localparam logic [OP_W-1:0] OPC_OUTM = 4'd8;

    typedef enum logic [3:0] {
        S_F_MAR,   // program counter -> MAR
        S_F_RD,    // memory samples MAR, program counter + 1
        S_F_MDR,   // read word -> MDR
        S_F_CIR,   // MDR -> CIR
        S_DEC,     // opcode inspected
        S_X_JMP,   // field -> program counter
        S_X_IMM,   // field -> MDR
        S_X_MAR,   // field -> MAR
        S_X_RD,    // memory samples MAR
        S_X_MDR,   // read word -> MDR
        S_X_ACC,   // MDR (or sum) -> accumulator
        S_X_STA,   // accumulator -> MDR
        S_X_WR,    // MDR written at MAR
        S_X_OUT,   // output register loaded
        S_RST      // control back to the program counter
    } state_e;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_cir;
        logic pc_inc;
        logic pc_from_cir;
        logic mdr_from_mem;
        logic mdr_from_imm;
        logic mdr_from_acc;
        logic cir_from_mdr;
        logic acc_load;
        logic acc_add;
        logic mem_we;
        logic out_fire;
        logic out_from_mdr;
    } ctl_t;

endpackage

// File: rtl/acc_cpu_seq.sv
// acc_cpu_seq: control unit. Walks fetch, decode, execute and reset
// phases one register transfer per cycle and emits the control word.
// Assumes the opcode input is the CIR opcode field, stable from decode
// to the end of execute.
module acc_cpu_seq
    import acc_cpu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op,
    output state_e          state,
    output ctl_t            ctl
);

    state_e state_nx;

    // Phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_F_MAR;
        else        state <= state_nx;
    end

    // Next phase from the current phase and the decoded opcode.
    always_comb begin
        state_nx = S_RST;
        unique case (state)
            S_F_MAR: state_nx = S_F_RD;
            S_F_RD:  state_nx = S_F_MDR;
            S_F_MDR: state_nx = S_F_CIR;
            S_F_CIR: state_nx = S_DEC;
            S_DEC: begin
                case (op)
                    OPC_JMP:                   state_nx = S_X_JMP;
                    OPC_LDI, OPC_ADI:          state_nx = S_X_IMM;
                    OPC_LDM, OPC_ADM,
                    OPC_STO, OPC_OUTM:         state_nx = S_X_MAR;
                    OPC_OUTA:                  state_nx = S_X_OUT;
                    default:                   state_nx = S_RST;
                endcase
            end
            S_X_IMM: state_nx = S_X_ACC;
            S_X_MAR: state_nx = (op == OPC_STO) ? S_X_STA : S_X_RD;
            S_X_RD:  state_nx = S_X_MDR;
            S_X_MDR: state_nx = (op == OPC_OUTM) ? S_X_OUT : S_X_ACC;
            S_X_STA: state_nx = S_X_WR;
            S_X_JMP, S_X_ACC, S_X_WR, S_X_OUT: state_nx = S_RST;
            S_RST:   state_nx = S_F_MAR;
            default: state_nx = S_F_MAR;
        endcase
    end

    // Control word: one register transfer per phase.
    always_comb begin
        ctl = '0;
        case (state)
            S_F_MAR: ctl.mar_from_pc  = 1'b1;
            S_F_RD:  ctl.pc_inc       = 1'b1;
            S_F_MDR: ctl.mdr_from_mem = 1'b1;
            S_F_CIR: ctl.cir_from_mdr = 1'b1;
            S_X_JMP: ctl.pc_from_cir  = 1'b1;
            S_X_IMM: ctl.mdr_from_imm = 1'b1;
            S_X_MAR: ctl.mar_from_cir = 1'b1;
            S_X_MDR: ctl.mdr_from_mem = 1'b1;
            S_X_STA: ctl.mdr_from_acc = 1'b1;
            S_X_WR:  ctl.mem_we       = 1'b1;
            S_X_ACC: begin
                ctl.acc_load = 1'b1;
                ctl.acc_add  = (op == OPC_ADI) || (op == OPC_ADM);
            end
            S_X_OUT: begin
                ctl.out_fire     = 1'b1;
                ctl.out_from_mdr = (op == OPC_OUTM);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_cpu_alu.sv
// acc_cpu_alu: accumulator input selector. Passes the operand through
// for a load, or returns the sum modulo 2**DATA_W for an add.
module acc_cpu_alu #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    input  logic              add,
    output logic [DATA_W-1:0] result
);

    // Load or wrapping add.
    always_comb begin
        result = add ? (acc + operand) : operand;
    end

endmodule

// File: rtl/acc_cpu_dp.sv
// acc_cpu_dp: programme-visible registers (program counter, MAR, MDR, CIR,
// accumulator) and the transfers between them. Each register takes at
// most one source per cycle, as chosen by the control word. Assumes
// DATA_W <= OP_W + ADDR_W.
module acc_cpu_dp
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  ctl_t                   ctl,
    input  logic [OP_W+ADDR_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0]      alu_result,
    output logic [ADDR_W-1:0]      pc,
    output logic [ADDR_W-1:0]      mar,
    output logic [OP_W+ADDR_W-1:0] mdr,
    output logic [OP_W+ADDR_W-1:0] cir,
    output logic [DATA_W-1:0]      acc,
    output logic [DATA_W-1:0]      mdr_data,
    output logic [OP_W-1:0]        op
);

    localparam int WORD_W = OP_W + ADDR_W;

    logic [ADDR_W-1:0] field;

    // Split the CIR into opcode and address/immediate field.
    always_comb begin
        op       = cir[WORD_W-1:ADDR_W];
        field    = cir[ADDR_W-1:0];
        mdr_data = mdr[DATA_W-1:0];
    end

    // Program counter: step by one during fetch, or take a jump target.
    always_ff @(posedge clk) begin
        if (!rst_n)               pc <= '0;
        else if (ctl.pc_inc)      pc <= pc + ADDR_W'(1);
        else if (ctl.pc_from_cir) pc <= field;
    end

    // MAR: next-instruction address or operand address.
    always_ff @(posedge clk) begin
        if (!rst_n)                mar <= '0;
        else if (ctl.mar_from_pc)  mar <= pc;
        else if (ctl.mar_from_cir) mar <= field;
    end

    // MDR: memory word, zero-extended immediate or zero-extended accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n)                mdr <= '0;
        else if (ctl.mdr_from_mem) mdr <= mem_rdata;
        else if (ctl.mdr_from_imm) mdr <= WORD_W'(field);
        else if (ctl.mdr_from_acc) mdr <= WORD_W'(acc);
    end

    // CIR: loaded from the MDR at the end of fetch only.
    always_ff @(posedge clk) begin
        if (!rst_n)                cir <= '0;
        else if (ctl.cir_from_mdr) cir <= mdr;
    end

    // Accumulator: takes the ALU result on a load or add.
    always_ff @(posedge clk) begin
        if (!rst_n)            acc <= '0;
        else if (ctl.acc_load) acc <= alu_result;
    end

endmodule

// File: rtl/acc_cpu_out.sv
// acc_cpu_out: registered output port. Captures the accumulator or the
// MDR data bits on a fire request and raises the valid strobe for that
// single following cycle.
module acc_cpu_out #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              from_mdr,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] mdr_data,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid
);

    // Valid strobe follows the fire request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= fire;
    end

    // Output value captured on fire.
    always_ff @(posedge clk) begin
        if (!rst_n)    out_data <= '0;
        else if (fire) out_data <= from_mdr ? mdr_data : acc;
    end

endmodule

// File: rtl/acc_cpu.sv
// acc_cpu: accumulator processor top. Connects the sequencer, datapath,
// ALU and output port. Assumes a synchronous memory that returns the
// word at mem_addr one clock after it is presented and writes on mem_we.
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic                   mem_we,
    output logic [OP_W+ADDR_W-1:0] mem_wdata,
    input  logic [OP_W+ADDR_W-1:0] mem_rdata,
    output logic [DATA_W-1:0]      out_data,
    output logic                   out_valid
);

    localparam int WORD_W = OP_W + ADDR_W;

    state_e              state;
    ctl_t                ctl;
    logic [OP_W-1:0]     op;
    logic [ADDR_W-1:0]   pc;
    logic [ADDR_W-1:0]   mar;
    logic [WORD_W-1:0]   mdr;
    logic [WORD_W-1:0]   cir;
    logic [DATA_W-1:0]   acc;
    logic [DATA_W-1:0]   mdr_data;
    logic [DATA_W-1:0]   alu_result;

    acc_cpu_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .state (state),
        .ctl   (ctl)
    );

    acc_cpu_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl        (ctl),
        .mem_rdata  (mem_rdata),
        .alu_result (alu_result),
        .pc         (pc),
        .mar        (mar),
        .mdr        (mdr),
        .cir        (cir),
        .acc        (acc),
        .mdr_data   (mdr_data),
        .op         (op)
    );

    acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
        .acc     (acc),
        .operand (mdr_data),
        .add     (ctl.acc_add),
        .result  (alu_result)
    );

    acc_cpu_out #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (ctl.out_fire),
        .from_mdr  (ctl.out_from_mdr),
        .acc       (acc),
        .mdr_data  (mdr_data),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    // Memory side is driven straight from the MAR and the MDR.
    always_comb begin
        mem_addr  = mar;
        mem_wdata = mdr;
        mem_we    = ctl.mem_we;
    end

endmodule

// File: rtl/acc_cpu_chk.sv
// acc_cpu_chk: cycle-level checks on the register transfers of acc_cpu,
// attached through bind. Observes only; drives nothing.
module acc_cpu_chk
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input state_e                 state,
    input logic [ADDR_W-1:0]      pc,
    input logic [OP_W+ADDR_W-1:0] cir,
    input logic [OP_W+ADDR_W-1:0] mdr,
    input logic [DATA_W-1:0]      acc,
    input logic                   out_valid,
    input logic                   mem_we,
    input logic [ADDR_W-1:0]      mem_addr,
    input logic [OP_W+ADDR_W-1:0] mem_wdata
);

    localparam int WORD_W = OP_W + ADDR_W;

    // R1: a reset edge leaves the ports quiet.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !mem_we && mem_addr == '0));

    // R2: the program counter advances by exactly one in fetch.
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_F_RD) |=> (pc == $past(pc) + ADDR_W'(1)));

    // R2: the CIR receives the fetched word from the MDR.
    a_r2_cir_from_mdr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_F_CIR) |=> (cir == $past(mdr)));

    // R3: a jump lands on the field of the held instruction.
    a_r3_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_X_JMP) |=> (pc == $past(cir[ADDR_W-1:0])));

    // R5: the CIR is held outside its load phase.
    a_r5_cir_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_F_CIR) |=> $stable(cir));

    // R5: additions wrap to the accumulator width.
    a_r5_add_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_X_ACC && (cir[WORD_W-1:ADDR_W] == OPC_ADI ||
                              cir[WORD_W-1:ADDR_W] == OPC_ADM))
        |=> (acc == $past(acc) + $past(mdr[DATA_W-1:0])));

    // R6: a write targets the field address with the accumulator as data.
    a_r6_store_target: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == cir[ADDR_W-1:0] && mem_wdata == WORD_W'(acc)));

    // R11: writes come only from a store instruction.
    a_r11_we_store_only: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (cir[WORD_W-1:ADDR_W] == OPC_STO));

    // R9: the output strobe never lasts two cycles.
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R10: the reset phase always returns to the first fetch step.
    a_r10_back_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RST) |=> (state == S_F_MAR));

endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .pc        (pc),
    .cir       (cir),
    .mdr       (mdr),
    .acc       (acc),
    .out_valid (out_valid),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/tb_acc_cpu.sv
// tb_acc_cpu: directed scenarios against acc_cpu with a memory model.
module tb_acc_cpu;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int WORD_W = 4 + ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we;
    logic [WORD_W-1:0] mem_wdata;
    logic [WORD_W-1:0] mem_rdata;
    logic [DATA_W-1:0] out_data;
    logic              out_valid;

    logic [WORD_W-1:0] mem [256];

    int n_tests = 0;
    int n_fail  = 0;
    int n_out   = 0;
    int n_we    = 0;
    int cyc     = 0;
    int outs   [32];
    int stamps [32];

    always #4 clk = ~clk;

    acc_cpu #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    // Synchronous single-port memory, read word one clock after the address.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    // Port monitor: records each valid output cycle and each write cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc = cyc + 1;
            if (out_valid && n_out < 32) begin
                outs[n_out]   = out_data;
                stamps[n_out] = cyc;
                n_out = n_out + 1;
            end
            if (mem_we) n_we = n_we + 1;
        end
    end

    function automatic logic [WORD_W-1:0] w(input int op, input int fld);
        return {op[3:0], fld[7:0]};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = '0;
    endtask

    // Holds reset, clears the monitors, releases at a falling edge.
    task automatic start();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        n_out = 0;
        n_we  = 0;
        cyc   = 0;
        rst_n = 1'b1;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R1: reset state and restart from address 0 in the middle of a program.
    task automatic t_reset();
        clear_mem();
        mem[0] = w(2, 8'h21);
        mem[1] = w(7, 0);
        mem[2] = w(2, 8'h33);
        mem[3] = w(7, 0);
        mem[4] = w(1, 4);
        start();
        run(40);
        check("R1 prog before reset, outputs", n_out, 2);
        rst_n = 1'b0;
        run(2);
        check("R1 out_valid in reset", int'(out_valid), 0);
        check("R1 mem_we in reset", int'(mem_we), 0);
        check("R1 mem_addr in reset", int'(mem_addr), 0);
        n_out = 0;
        n_we  = 0;
        cyc   = 0;
        rst_n = 1'b1;
        run(20);
        check("R1 restart count", n_out, 1);
        check("R1 restart from addr 0", outs[0], 8'h21);
    endtask

    // R2 / R5: consecutive fetch, immediate load and add.
    task automatic t_seq();
        clear_mem();
        mem[0] = w(2, 5);
        mem[1] = w(7, 0);
        mem[2] = w(5, 3);
        mem[3] = w(7, 0);
        mem[4] = w(1, 4);
        start();
        run(80);
        check("R2 output count", n_out, 2);
        check("R2 load immediate", outs[0], 5);
        check("R5 add immediate", outs[1], 8);
    endtask

    // R3: jump skips an output and continues at the target.
    task automatic t_jump();
        clear_mem();
        mem[0]     = w(1, 8'h10);
        mem[1]     = w(7, 0);
        mem[8'h10] = w(2, 9);
        mem[8'h11] = w(7, 0);
        mem[8'h12] = w(1, 8'h12);
        start();
        run(80);
        check("R3 jump output count", n_out, 1);
        check("R3 jump target value", outs[0], 9);
    endtask

    // R4: load and add from memory, upper word bits ignored, sum wraps.
    task automatic t_mem();
        clear_mem();
        mem[8'h40] = 12'hA1E;
        mem[8'h41] = 12'h0FA;
        mem[0] = w(3, 8'h40);
        mem[1] = w(7, 0);
        mem[2] = w(6, 8'h41);
        mem[3] = w(7, 0);
        mem[4] = w(1, 4);
        start();
        run(80);
        check("R4 load from memory", outs[0], 30);
        check("R4 add from memory wraps", outs[1], 24);
    endtask

    // R5: immediate addition wraps modulo 256.
    task automatic t_wrap();
        clear_mem();
        mem[0] = w(2, 200);
        mem[1] = w(5, 100);
        mem[2] = w(7, 0);
        mem[3] = w(1, 3);
        start();
        run(60);
        check("R5 immediate wrap", outs[0], 44);
    endtask

    // R6 / R11: store writes once, zero-extended, then reads back.
    task automatic t_store();
        clear_mem();
        mem[8'h80] = 12'hFFF;
        mem[0] = w(2, 8'h5A);
        mem[1] = w(4, 8'h80);
        mem[2] = w(8, 8'h80);
        mem[3] = w(1, 3);
        start();
        run(80);
        check("R6 stored word", int'(mem[8'h80]), 12'h05A);
        check("R11 write count", n_we, 1);
        check("R6 read back", outs[0], 8'h5A);
    endtask

    // R7: output from memory leaves the accumulator untouched.
    task automatic t_outm();
        clear_mem();
        mem[8'h40] = 12'd30;
        mem[0] = w(2, 7);
        mem[1] = w(8, 8'h40);
        mem[2] = w(7, 0);
        mem[3] = w(1, 3);
        start();
        run(80);
        check("R7 output from memory", outs[0], 30);
        check("R7 accumulator kept", outs[1], 7);
    endtask

    // R8: undefined opcodes change nothing.
    task automatic t_undef();
        clear_mem();
        mem[0] = w(2, 3);
        mem[1] = w(0, 8'hAB);
        mem[2] = w(9, 8'hCD);
        mem[3] = w(15, 8'h12);
        mem[4] = w(7, 0);
        mem[5] = w(1, 5);
        start();
        run(100);
        check("R8 no write", n_we, 0);
        check("R8 single output", n_out, 1);
        check("R8 accumulator unchanged", outs[0], 3);
    endtask

    // R9 / R10: strobe length and cycle spacing per instruction class.
    task automatic t_timing();
        clear_mem();
        mem[8'h40] = 12'd30;
        mem[0]  = w(7, 0);
        mem[1]  = w(7, 0);
        mem[2]  = w(0, 0);
        mem[3]  = w(7, 0);
        mem[4]  = w(2, 8'h11);
        mem[5]  = w(7, 0);
        mem[6]  = w(3, 8'h40);
        mem[7]  = w(7, 0);
        mem[8]  = w(4, 8'h90);
        mem[9]  = w(7, 0);
        mem[10] = w(1, 11);
        mem[11] = w(7, 0);
        mem[12] = w(1, 12);
        start();
        run(160);
        check("R9 one valid cycle per output", n_out, 7);
        check("R1 accumulator zero after reset", outs[0], 0);
        check("R10 output accumulator spacing", stamps[1] - stamps[0], 7);
        check("R10 no-op spacing", stamps[2] - stamps[1], 13);
        check("R10 immediate spacing", stamps[3] - stamps[2], 15);
        check("R10 memory load spacing", stamps[4] - stamps[3], 17);
        check("R10 store spacing", stamps[5] - stamps[4], 16);
        check("R10 jump spacing", stamps[6] - stamps[5], 14);
        check("R4 load value in timing run", outs[4], 30);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        clear_mem();
        rst_n = 1'b0;
        run(2);
        check("R1 out_valid at reset", int'(out_valid), 0);
        check("R1 mem_addr at reset", int'(mem_addr), 0);
        t_reset();
        t_seq();
        t_jump();
        t_mem();
        t_wrap();
        t_store();
        t_outm();
        t_undef();
        t_timing();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule